// File: doc/BRIEF.md
# Split TLB Maintenance Controller

This block holds the translation entries of a two-part TLB and carries out the maintenance commands that system software issues against them. The first part is set-associative, 8 ways of 256 sets. All of its entries share one page size, which arrives on an input. The second part is a small fully associative array that keeps a page size in each entry. Each entry holds an enable flag, a 10-bit address-space identifier, the virtual page-pair number and two low words. The low words describe the even and odd pages of the pair, and bit 6 of the first low word is the entry's global flag.

A command port delivers the opcode together with an index, the current ASID, a virtual address, a page size, a not-present flag, two low words and a global-match value. The block raises busy while it works and pulses done for one cycle when it finishes. Read results stay on the read outputs until the next read. A write or a fill reports which entry it overwrote, and it also reports whether that entry's old contents must be dropped from any downstream translation cache. Multi-entry commands sweep one entry per clock.

Top module: `split_tlb_maint`

## Requirements
- R1: After reset busy and done are low and every entry is disabled, so a read of any index returns the not-present flag.
- R2: A read of an enabled entry returns not-present 0, its ASID, entry-hi equal to the page-pair number shifted left by 13, both low words, and its page size. Set-associative entries (index below 2048) report the global page size. A read of a disabled or out-of-range index returns not-present 1 with ASID, entry-hi, low words and page size all zero.
- R3: A write stores at the given index the address bits 47 down to 13, the command ASID, both low words and the page size, and it sets the enable flag. The page size is kept only for entries at index 2048 and above. A write with the not-present flag set only clears the enable flag of that entry.
- R4: When the requested page size equals the global size, a fill targets index way*256+set, with set = (VA >> (ps+1)) mod 256 and a pseudo-random way in 0..7. Otherwise it targets a pseudo-random entry in 2048..2111. In both cases wr_valid and wr_index report the target in the done cycle.
- R5: In the done cycle of a write or fill, evict_valid is high, with evict_index equal to the target, exactly when the overwritten entry was global or carried the command ASID.
- R6: Clear with an index below 2048 visits the 8 ways of set index mod 256. With an index from 2048 to 2111 it visits every fully associative entry. It disables each visited entry that is non-global and carries the command ASID.
- R7: Flush visits the same entries as clear and disables each one unconditionally. Clear or flush with an index of 2112 or more changes nothing.
- R8: Invalidate-all disables every entry. Invalidate-by-global disables every entry whose global flag equals the command's global-match value.
- R9: Invalidate-by-ASID disables every non-global entry that carries the command ASID.
- R10: Invalidate-page-by-ASID disables every non-global entry that carries the command ASID and whose page pair matches. A page pair matches when VA >> (ps+1) equals entry-hi >> (ps+1), where ps is the entry's own page size.
- R11: Invalidate-page-by-ASID-or-global disables every entry whose page pair matches and that is either global or carries the command ASID.
- R12: Opcodes are 0 read, 1 write, 2 fill, 3 clear, 4 flush, 5 invalidate-all, 6 invalidate-by-global, 7 invalidate-by-ASID, 8 invalidate-page-by-ASID and 9 invalidate-page-by-ASID-or-global. A command is accepted on a clock edge where cmd_valid is high and busy is low. Busy then stays high for exactly N cycles and done pulses in the cycle in which busy falls. N is 1 for read, write, fill and out-of-range clear or flush, 8 for a set sweep, 64 for a fully associative sweep and 2112 for the invalidate commands. cmd_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 4 | Opcode |
| cmd_index | input | 12 | Entry index for read, write, clear and flush |
| cmd_asid | input | 10 | Current or given ASID |
| cmd_va | input | 48 | Virtual address |
| cmd_ps | input | 6 | Requested page size for write and fill |
| cmd_ne | input | 1 | Not-present flag for write |
| cmd_lo0 | input | 32 | Even-page low word; bit 6 is the global flag |
| cmd_lo1 | input | 32 | Odd-page low word |
| cmd_g | input | 1 | Global value for invalidate-by-global |
| glob_ps | input | 6 | Page size shared by the set-associative part |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_ne | output | 1 | Read: entry not present |
| rd_asid | output | 10 | Read: ASID |
| rd_ehi | output | 48 | Read: entry-hi |
| rd_lo0 | output | 32 | Read: even low word |
| rd_lo1 | output | 32 | Read: odd low word |
| rd_ps | output | 6 | Read: page size |
| wr_valid | output | 1 | Write or fill target valid |
| wr_index | output | 12 | Write or fill target index |
| evict_valid | output | 1 | Downstream invalidation required |
| evict_index | output | 12 | Entry to drop downstream |

## Verification
A wrong enable flag or a stale field stays hidden inside the arrays until it reaches a port. It shows up at the next read of that entry, in the not-present flag or in a field value. It also shows up in the evict decision of the next write or fill that lands on the entry. For that reason the stimulus reads back every entry that a command could have touched, right after the command completes. A miscounted sweep shows up without delay: the busy length and the position of the done pulse are compared against the reference model on every clock.

// File: rtl/split_tlb_maint.sv
module split_tlb_maint #(
  parameter int WAY_AW   = 3,
  parameter int SET_AW   = 8,
  parameter int FA_AW    = 6,
  parameter int VAW      = 48,
  parameter int LOW      = 32,
  parameter int ASW      = 10,
  parameter int PSW      = 6,
  parameter int VPPN_LSB = 13,
  parameter int G_BIT    = 6,
  localparam int TOTAL   = (1 << (WAY_AW + SET_AW)) + (1 << FA_AW),
  localparam int IDXW    = $clog2(TOTAL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [IDXW-1:0] cmd_index,
  input  logic [ASW-1:0]  cmd_asid,
  input  logic [VAW-1:0]  cmd_va,
  input  logic [PSW-1:0]  cmd_ps,
  input  logic            cmd_ne,
  input  logic [LOW-1:0]  cmd_lo0,
  input  logic [LOW-1:0]  cmd_lo1,
  input  logic            cmd_g,
  input  logic [PSW-1:0]  glob_ps,
  output logic            busy,
  output logic            done,
  output logic            rd_ne,
  output logic [ASW-1:0]  rd_asid,
  output logic [VAW-1:0]  rd_ehi,
  output logic [LOW-1:0]  rd_lo0,
  output logic [LOW-1:0]  rd_lo1,
  output logic [PSW-1:0]  rd_ps,
  output logic            wr_valid,
  output logic [IDXW-1:0] wr_index,
  output logic            evict_valid,
  output logic [IDXW-1:0] evict_index
);
  localparam int WAYS = 1 << WAY_AW;
  localparam int SA_N = 1 << (WAY_AW + SET_AW);
  localparam int FA_N = 1 << FA_AW;
  localparam int VPW  = VAW - VPPN_LSB;

  localparam logic [3:0] OP_READ    = 4'd0;
  localparam logic [3:0] OP_WRITE   = 4'd1;
  localparam logic [3:0] OP_FILL    = 4'd2;
  localparam logic [3:0] OP_CLEAR   = 4'd3;
  localparam logic [3:0] OP_FLUSH   = 4'd4;
  localparam logic [3:0] OP_INV_ALL = 4'd5;
  localparam logic [3:0] OP_INV_G   = 4'd6;
  localparam logic [3:0] OP_INV_AS  = 4'd7;
  localparam logic [3:0] OP_INV_PA  = 4'd8;
  localparam logic [3:0] OP_INV_PAG = 4'd9;

  logic [TOTAL-1:0] ent_e;
  logic [ASW-1:0]   ent_asid [TOTAL];
  logic [VPW-1:0]   ent_vppn [TOTAL];
  logic [LOW-1:0]   ent_lo0  [TOTAL];
  logic [LOW-1:0]   ent_lo1  [TOTAL];
  logic [PSW-1:0]   ent_ps   [FA_N];

  logic [3:0]      op_q;
  logic [IDXW-1:0] idx_q, cnt, cnt_end;
  logic [ASW-1:0]  asid_q;
  logic [VAW-1:0]  va_q;
  logic [PSW-1:0]  ps_q;
  logic [LOW-1:0]  lo0_q, lo1_q;
  logic            ne_q, g_q, sa_q, nop_q;
  logic [15:0]     lfsr;

  logic [IDXW-1:0] tgt, tsel, fa_rel, fill_pick, cnt_end_c;
  logic            in_rng, is_fa, act, wr_op, clr_only, kill_c, nop_c;
  logic            g_t, asid_hit, pg_hit;
  logic [PSW-1:0]  ps_t;
  logic [PSW:0]    sh_t, sh_c;
  logic [VAW-1:0]  ehi_t, pmask, set_c;

  always_comb begin
    case (op_q)
      OP_CLEAR, OP_FLUSH:
        tgt = sa_q ? IDXW'({cnt[WAY_AW-1:0], idx_q[SET_AW-1:0]}) : IDXW'(SA_N) + cnt;
      OP_INV_ALL, OP_INV_G, OP_INV_AS, OP_INV_PA, OP_INV_PAG:
        tgt = cnt;
      default:
        tgt = idx_q;
    endcase
  end

  assign in_rng   = tgt < IDXW'(TOTAL);
  assign tsel     = in_rng ? tgt : '0;
  assign is_fa    = tsel >= IDXW'(SA_N);
  assign fa_rel   = tsel - IDXW'(SA_N);
  assign ps_t     = is_fa ? ent_ps[fa_rel[FA_AW-1:0]] : glob_ps;
  assign ehi_t    = {ent_vppn[tsel], {VPPN_LSB{1'b0}}};
  assign g_t      = ent_lo0[tsel][G_BIT];
  assign asid_hit = ent_asid[tsel] == asid_q;
  assign sh_t     = {1'b0, ps_t} + {{PSW{1'b0}}, 1'b1};
  assign pmask    = {VAW{1'b1}} << sh_t;
  assign pg_hit   = ((va_q ^ ehi_t) & pmask) == '0;
  assign wr_op    = (op_q == OP_WRITE) || (op_q == OP_FILL);
  assign clr_only = (op_q == OP_WRITE) && ne_q;
  assign act      = busy && in_rng && !nop_q;

  always_comb begin
    case (op_q)
      OP_CLEAR, OP_INV_AS:  kill_c = !g_t && asid_hit;
      OP_FLUSH, OP_INV_ALL: kill_c = 1'b1;
      OP_INV_G:             kill_c = g_t == g_q;
      OP_INV_PA:            kill_c = !g_t && asid_hit && pg_hit;
      OP_INV_PAG:           kill_c = (g_t || asid_hit) && pg_hit;
      default:              kill_c = 1'b0;
    endcase
  end

  assign sh_c  = {1'b0, cmd_ps} + {{PSW{1'b0}}, 1'b1};
  assign set_c = cmd_va >> sh_c;
  assign fill_pick = (cmd_ps == glob_ps)
                   ? IDXW'({lfsr[WAY_AW-1:0], set_c[SET_AW-1:0]})
                   : IDXW'(SA_N) + IDXW'(lfsr[FA_AW-1:0]);

  always_comb begin
    cnt_end_c = '0;
    nop_c     = 1'b0;
    case (cmd_op)
      OP_CLEAR, OP_FLUSH:
        if (cmd_index < IDXW'(SA_N))       cnt_end_c = IDXW'(WAYS - 1);
        else if (cmd_index < IDXW'(TOTAL)) cnt_end_c = IDXW'(FA_N - 1);
        else                               nop_c = 1'b1;
      OP_INV_ALL, OP_INV_G, OP_INV_AS, OP_INV_PA, OP_INV_PAG:
        cnt_end_c = IDXW'(TOTAL - 1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; cnt_end <= '0;
      op_q <= OP_READ; idx_q <= '0; asid_q <= '0; va_q <= '0; ps_q <= '0;
      lo0_q <= '0; lo1_q <= '0; ne_q <= 1'b0; g_q <= 1'b0; sa_q <= 1'b0; nop_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy    <= 1'b1;
          cnt     <= '0;
          cnt_end <= cnt_end_c;
          op_q    <= cmd_op;
          idx_q   <= (cmd_op == OP_FILL) ? fill_pick : cmd_index;
          asid_q  <= cmd_asid;
          va_q    <= cmd_va;
          ps_q    <= cmd_ps;
          lo0_q   <= cmd_lo0;
          lo1_q   <= cmd_lo1;
          ne_q    <= cmd_ne;
          g_q     <= cmd_g;
          sa_q    <= cmd_index < IDXW'(SA_N);
          nop_q   <= nop_c;
        end
      end else if (cnt == cnt_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + IDXW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_e <= '0;
    else if (act) begin
      if (kill_c)     ent_e[tsel] <= 1'b0;
      else if (wr_op) ent_e[tsel] <= !clr_only;
    end
  end

  always_ff @(posedge clk) begin
    if (act && wr_op && !clr_only) begin
      ent_asid[tsel] <= asid_q;
      ent_vppn[tsel] <= va_q[VAW-1:VPPN_LSB];
      ent_lo0[tsel]  <= lo0_q;
      ent_lo1[tsel]  <= lo1_q;
      if (is_fa) ent_ps[fa_rel[FA_AW-1:0]] <= ps_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ne <= 1'b0; rd_asid <= '0; rd_ehi <= '0; rd_lo0 <= '0; rd_lo1 <= '0; rd_ps <= '0;
    end else if (busy && op_q == OP_READ) begin
      if (in_rng && ent_e[tsel]) begin
        rd_ne <= 1'b0; rd_asid <= ent_asid[tsel]; rd_ehi <= ehi_t;
        rd_lo0 <= ent_lo0[tsel]; rd_lo1 <= ent_lo1[tsel]; rd_ps <= ps_t;
      end else begin
        rd_ne <= 1'b1; rd_asid <= '0; rd_ehi <= '0; rd_lo0 <= '0; rd_lo1 <= '0; rd_ps <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0; wr_index <= '0; evict_valid <= 1'b0; evict_index <= '0;
    end else begin
      wr_valid    <= 1'b0;
      evict_valid <= 1'b0;
      if (act && wr_op) begin
        wr_valid    <= 1'b1;
        wr_index    <= tsel;
        evict_valid <= g_t || asid_hit;
        evict_index <= tsel;
      end
    end
  end

  p_done_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_busy_falls_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_accept_needs_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  p_absent_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ne |-> (rd_asid == '0 && rd_ehi == '0 && rd_lo0 == '0 && rd_lo1 == '0 && rd_ps == '0));
  p_evict_tracks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (wr_valid && done && evict_index == wr_index));
  p_write_target_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_index < IDXW'(TOTAL)));
endmodule

// File: tb/split_tlb_maint_tb.sv
`timescale 1ns/1ps
module split_tlb_maint_tb;
  localparam int TOTAL = 2112;
  localparam int SA_N  = 2048;
  localparam int SPS   = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [11:0] cmd_index = '0;
  logic [9:0]  cmd_asid = '0;
  logic [47:0] cmd_va = '0;
  logic [5:0]  cmd_ps = '0;
  logic        cmd_ne = 1'b0;
  logic [31:0] cmd_lo0 = '0, cmd_lo1 = '0;
  logic        cmd_g = 1'b0;
  logic [5:0]  glob_ps = 6'(SPS);
  logic        busy, done, rd_ne, wr_valid, evict_valid;
  logic [9:0]  rd_asid;
  logic [47:0] rd_ehi;
  logic [31:0] rd_lo0, rd_lo1;
  logic [5:0]  rd_ps;
  logic [11:0] wr_index, evict_index;

  always #4 clk = ~clk;

  split_tlb_maint u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_index(cmd_index), .cmd_asid(cmd_asid), .cmd_va(cmd_va), .cmd_ps(cmd_ps),
    .cmd_ne(cmd_ne), .cmd_lo0(cmd_lo0), .cmd_lo1(cmd_lo1), .cmd_g(cmd_g),
    .glob_ps(glob_ps), .busy(busy), .done(done), .rd_ne(rd_ne), .rd_asid(rd_asid),
    .rd_ehi(rd_ehi), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1), .rd_ps(rd_ps),
    .wr_valid(wr_valid), .wr_index(wr_index), .evict_valid(evict_valid),
    .evict_index(evict_index));

  bit     me [TOTAL];
  bit     mw [TOTAL];
  int     masid [TOTAL];
  longint mehi [TOTAL];
  longint ml0 [TOTAL];
  longint ml1 [TOTAL];
  int     mps [TOTAL];

  int     mb = 0;
  bit     md = 1'b0;
  int     p_op, p_idx, p_asid, p_ps;
  longint p_va, p_lo0, p_lo1;
  bit     p_ne, p_g;
  int     checks = 0, errors = 0;
  string  req = "R1";
  int     last_wr = 0;
  bit     finished = 1'b0;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic int eps(input int i);
    return (i >= SA_N) ? mps[i] : SPS;
  endfunction

  function automatic bit glb(input int i);
    return ml0[i][6];
  endfunction

  function automatic bit pmatch(input int i, input longint va);
    int s = eps(i) + 1;
    return (va >> s) == (mehi[i] >> s);
  endfunction

  function automatic int op_len(input int op, input int idx);
    if (op == 3 || op == 4) return (idx < SA_N) ? 8 : (idx < TOTAL) ? 64 : 1;
    if (op >= 5 && op <= 9) return TOTAL;
    return 1;
  endfunction

  task automatic kill_if(input int i, input bit c);
    if (c) me[i] = 1'b0;
  endtask

  task automatic apply();
    case (p_op)
      0: begin
        bit e = (p_idx < TOTAL) && me[p_idx];
        chk(rd_ne == !e, req, rd_ne, !e);
        chk(rd_asid == (e ? masid[p_idx] : 0), req, rd_asid, e ? masid[p_idx] : 0);
        chk(rd_ehi == (e ? mehi[p_idx] : 0), req, rd_ehi, e ? mehi[p_idx] : 0);
        chk(rd_lo0 == (e ? ml0[p_idx] : 0), req, rd_lo0, e ? ml0[p_idx] : 0);
        chk(rd_lo1 == (e ? ml1[p_idx] : 0), req, rd_lo1, e ? ml1[p_idx] : 0);
        chk(rd_ps == (e ? eps(p_idx) : 0), req, rd_ps, e ? eps(p_idx) : 0);
      end
      1, 2: begin
        int i;
        if (p_op == 2) begin
          i = wr_index;
          if (p_ps == SPS)
            chk(i < SA_N && (i % 256) == ((p_va >> (SPS + 1)) & 255), "R4", i, (p_va >> (SPS + 1)) & 255);
          else
            chk(i >= SA_N && i < TOTAL, "R4", i, SA_N);
        end else begin
          i = p_idx;
          chk(wr_index == p_idx, req, wr_index, p_idx);
        end
        chk(wr_valid == 1'b1, req, wr_valid, 1);
        if (mw[i]) begin
          bit ev = glb(i) || (masid[i] == p_asid);
          chk(evict_valid == ev, "R5", evict_valid, ev);
          if (ev) chk(evict_index == i, "R5", evict_index, i);
        end
        if (p_op == 1 && p_ne) me[i] = 1'b0;
        else begin
          me[i] = 1'b1; mw[i] = 1'b1; masid[i] = p_asid;
          mehi[i] = p_va & 64'hFFFF_FFFF_E000;
          ml0[i] = p_lo0; ml1[i] = p_lo1;
          if (i >= SA_N) mps[i] = p_ps;
        end
        last_wr = i;
      end
      3, 4: begin
        chk(wr_valid == 1'b0, req, wr_valid, 0);
        if (p_idx < SA_N) begin
          for (int w = 0; w < 8; w++) begin
            int i = w * 256 + (p_idx % 256);
            kill_if(i, p_op == 4 || (!glb(i) && masid[i] == p_asid));
          end
        end else if (p_idx < TOTAL) begin
          for (int i = SA_N; i < TOTAL; i++)
            kill_if(i, p_op == 4 || (!glb(i) && masid[i] == p_asid));
        end
      end
      5, 6, 7, 8, 9: begin
        for (int i = 0; i < TOTAL; i++) begin
          case (p_op)
            5: kill_if(i, 1'b1);
            6: kill_if(i, glb(i) == p_g);
            7: kill_if(i, !glb(i) && masid[i] == p_asid);
            8: kill_if(i, !glb(i) && masid[i] == p_asid && pmatch(i, p_va));
            default: kill_if(i, (glb(i) || masid[i] == p_asid) && pmatch(i, p_va));
          endcase
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mb = 0; md = 1'b0;
    end else begin
      md = 1'b0;
      if (mb > 0) begin
        mb--;
        if (mb == 0) md = 1'b1;
      end else if (cmd_valid) begin
        p_op = cmd_op; p_idx = cmd_index; p_asid = cmd_asid; p_va = cmd_va;
        p_ps = cmd_ps; p_ne = cmd_ne; p_lo0 = cmd_lo0; p_lo1 = cmd_lo1; p_g = cmd_g;
        mb = op_len(p_op, p_idx);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (mb > 0), "R12", busy, mb > 0);
      chk(done == md, "R12", done, md);
      if (md) apply();
    end
  end

  task automatic start(input int op, input int idx, input int asid, input longint va,
                       input int ps, input bit ne, input longint lo0, input longint lo1, input bit g);
    @(negedge clk);
    cmd_op = 4'(op); cmd_index = 12'(idx); cmd_asid = 10'(asid); cmd_va = 48'(va);
    cmd_ps = 6'(ps); cmd_ne = ne; cmd_lo0 = 32'(lo0); cmd_lo1 = 32'(lo1); cmd_g = g;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input int op, input int idx, input int asid, input longint va,
                       input int ps, input bit ne, input longint lo0, input longint lo1, input bit g);
    start(op, idx, asid, va, ps, ne, lo0, lo1, g);
    wait_idle();
  endtask

  task automatic rd(input int idx);
    issue(0, idx, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int idx, input int asid, input longint va, input int ps, input longint lo0);
    issue(1, idx, asid, va, ps, 0, lo0, lo0 + 64'h100, 0);
  endtask

  task automatic cmd(input int op, input int idx, input int asid, input longint va, input bit g);
    issue(op, idx, asid, va, 0, 0, 0, 0, g);
  endtask

  task automatic rd_list();
    int l [14] = '{5, 261, 517, 10, 11, 12, 2048, 2049, 2050, 2055, 2056, 773, 1029, 2111};
    foreach (l[k]) rd(l[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12: actual watchdog expiry expected completion");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);
    rd(0); rd(2111); rd(1000);

    req = "R3";
    wr(5,    3, 48'h1234_5678_A000, 14, 64'h1003);
    wr(261,  3, 48'h0000_0012_0000, 14, 64'h3043);
    wr(517,  7, 48'h0000_0034_4000, 14, 64'h1005);
    wr(2048, 3, 48'h0000_4020_0000, 21, 64'h2007);
    wr(2049, 3, 48'h0000_0066_6000, 16, 64'h2009);
    wr(2050, 9, 48'h0000_0800_0000, 25, 64'h2041);
    req = "R2";
    rd_list();
    req = "R5";
    wr(5,   3, 48'h0000_0077_0000, 14, 64'h1103);
    wr(517, 3, 48'h0000_0035_0000, 14, 64'h1203);
    req = "R3";
    issue(1, 2049, 3, 0, 0, 1, 0, 0, 0);
    rd(2049); rd(5); rd(517);

    req = "R4";
    issue(2, 0, 3, 48'h0000_0ABC_8000, SPS, 0, 64'h4003, 64'h4004, 0);
    rd(last_wr);
    issue(2, 0, 4, 48'h0000_0123_0000, SPS, 0, 64'h4043, 64'h4044, 0);
    rd(last_wr);
    issue(2, 0, 3, 48'h0000_0C00_0000, 21, 0, 64'h5003, 64'h5004, 0);
    rd(last_wr);
    issue(2, 0, 6, 48'h0000_1C00_0000, 18, 0, 64'h5043, 64'h5044, 0);
    rd(last_wr);

    req = "R6";
    cmd(3, 5, 3, 0, 0);
    rd(5); rd(261); rd(517);
    cmd(3, 2060, 3, 0, 0);
    rd(2048); rd(2050);

    req = "R7";
    wr(773, 1, 48'h0000_0001_0000, 14, 64'h0043);
    wr(1029, 2, 48'h0000_0002_0000, 14, 64'h0003);
    cmd(4, 3000, 1, 0, 0);
    rd(773); rd(1029);
    cmd(4, 261, 1, 0, 0);
    rd(261); rd(773); rd(1029);

    req = "R12";
    wr(20, 1, 48'h0000_0003_0000, 14, 64'h0003);
    start(4, 2100, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    cmd_op = 4'd1; cmd_index = 12'd21; cmd_asid = 10'd1; cmd_ne = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    rd(21); rd(20);

    req = "R10";
    wr(10,   4, 48'h0000_0040_8000, 14, 64'h0003);
    wr(11,   4, 48'h0000_0040_0000, 14, 64'h0003);
    wr(12,   5, 48'h0000_0040_8000, 14, 64'h0003);
    wr(2055, 4, 48'h0000_0040_0000, 21, 64'h0003);
    wr(2056, 5, 48'h0000_0040_0000, 21, 64'h0043);
    cmd(8, 0, 4, 48'h0000_0040_9000, 0);
    rd_list();
    req = "R11";
    cmd(9, 0, 9, 48'h0000_0040_9000, 0);
    rd_list();
    wr(10, 4, 48'h0000_0040_8000, 14, 64'h0003);
    cmd(9, 0, 4, 48'h0000_0040_8000, 0);
    rd(10); rd(12);

    req = "R9";
    wr(30, 8, 48'h0000_0050_0000, 14, 64'h0003);
    wr(31, 8, 48'h0000_0051_0000, 14, 64'h0043);
    wr(2060, 8, 48'h0000_0060_0000, 20, 64'h0003);
    cmd(7, 0, 8, 0, 0);
    rd(30); rd(31); rd(2060);

    req = "R8";
    wr(40, 2, 48'h0000_0070_0000, 14, 64'h0043);
    wr(41, 2, 48'h0000_0071_0000, 14, 64'h0003);
    cmd(6, 0, 0, 0, 1);
    rd(40); rd(41); rd(31);
    cmd(5, 0, 0, 0, 0);
    rd(41); rd(20); rd(2056);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule